// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, A and B, and moves data across them in one direction at a time. Each side has its own holding register, loaded on the rising edge of that side's own capture clock. On every edge the value on the bus is taken in. This happens even when neither bus is driven, so the block can store a word while the buses are isolated.

The word sent to the driven side comes from one of two sources. It can be the live value on the opposite bus, or the word held in that opposite bus's register. A per-direction select picks between them.

Two controls decide which bus is driven:
- An isolate input releases both buses.
- A direction input picks B or A as the driven side when the buses are not isolated.

Each bus appears as separate input, output and output-enable signals, so the block needs no tri-state net. A bus that is not driven shows zero on its output lines. An active-low asynchronous reset clears both registers.

Top module: `dual_bus_xcvr`

## Requirements
- R1: `hold_a` loads `a_in` on every rising edge of `cap_clk_a`, and `hold_b` loads `b_in` on every rising edge of `cap_clk_b`. This happens whatever the values of `isolate`, `toward_b` and the selects.
- R2: While `isolate` is 1, both `a_oe` and `b_oe` are 0, at any value of `toward_b`.
- R3: While `isolate` is 0, `toward_b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `toward_b` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R4: While `b_oe` = 1 and `a_use_held` = 0, `b_out` equals `a_in` in the same cycle.
- R5: While `b_oe` = 1 and `a_use_held` = 1, `b_out` equals the A holding register and does not follow changes on `a_in`.
- R6: While `a_oe` = 1 and `b_use_held` = 0, `a_out` equals `b_in` in the same cycle.
- R7: While `a_oe` = 1 and `b_use_held` = 1, `a_out` equals the B holding register and does not follow changes on `b_in`.
- R8: When the driven side uses the held word, a capture edge on the opposite side makes the newly captured word appear on the driven output straight after that edge.
- R9: `b_use_held` has no effect on the outputs while `toward_b` = 1, and `a_use_held` has no effect while `toward_b` = 0.
- R10: An output whose enable is 0 reads all zeros.
- R11: While `rst_n` is 0, both holding registers are zero, so held-mode outputs read 0x00 before any capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk_a | input | 1 | Capture clock of the A holding register, rising edge |
| cap_clk_b | input | 1 | Capture clock of the B holding register, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| isolate | input | 1 | 1 releases both buses |
| toward_b | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| a_use_held | input | 1 | Source for B: 0 live `a_in`, 1 A register |
| b_use_held | input | 1 | Source for A: 0 live `b_in`, 1 B register |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value driven onto bus A, zero when not enabled |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value driven onto bus B, zero when not enabled |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Capture and output routing can fall in the same cycle: a register is loaded by its clock edge while the driven side is reading that very register in held mode. The bench provokes this in both directions. It sets a fresh value on the input bus, pulses the capture clock with held mode on, and then checks that the driven output already shows the new word. It also checks that a word captured while the buses were isolated is still driven after the live input has changed.

// File: rtl/dual_bus_xcvr_pkg.sv
package dual_bus_xcvr_pkg;

    localparam int unsigned XCVR_WIDTH_DEF = 8;
    localparam int unsigned XCVR_LANES     = 2;

    // lane index: which bus a lane drives
    localparam int unsigned LANE_TO_A = 0;
    localparam int unsigned LANE_TO_B = 1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_A    = 2'b01,
        TGT_B    = 2'b10
    } xcvr_target_e;

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             cap_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] held
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.word = bus_in;   // capture is unconditional on each edge
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign held = state_q.word;

endmodule

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec
    import dual_bus_xcvr_pkg::*;
(
    input  logic isolate,
    input  logic toward_b,
    output logic a_oe,
    output logic b_oe
);

    xcvr_target_e target;

    always_comb begin
        if (isolate) begin
            target = TGT_NONE;
        end else if (toward_b) begin
            target = TGT_B;
        end else begin
            target = TGT_A;
        end
    end

    assign a_oe = (target == TGT_A);
    assign b_oe = (target == TGT_B);

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             enable,
    input  logic             use_held,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] drive
);

    logic [WIDTH-1:0] picked;

    always_comb begin
        picked = use_held ? held : live;
        drive  = enable ? picked : '0;
    end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import dual_bus_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH_DEF
) (
    input  logic             cap_clk_a,
    input  logic             cap_clk_b,
    input  logic             rst_n,
    input  logic             isolate,
    input  logic             toward_b,
    input  logic             a_use_held,
    input  logic             b_use_held,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    // per-lane views; lane LANE_TO_A drives bus A, lane LANE_TO_B drives bus B
    logic             lane_clk  [XCVR_LANES];
    logic [WIDTH-1:0] lane_cap  [XCVR_LANES];   // bus captured by the lane's source register
    logic [WIDTH-1:0] lane_held [XCVR_LANES];
    logic             lane_sel  [XCVR_LANES];
    logic             lane_en   [XCVR_LANES];
    logic [WIDTH-1:0] lane_out  [XCVR_LANES];

    logic [WIDTH-1:0] hold_a;
    logic [WIDTH-1:0] hold_b;

    xcvr_drive_dec u_dec (
        .isolate  (isolate),
        .toward_b (toward_b),
        .a_oe     (a_oe),
        .b_oe     (b_oe)
    );

    // lane toward A takes B-side data; lane toward B takes A-side data
    assign lane_clk[LANE_TO_A] = cap_clk_b;
    assign lane_cap[LANE_TO_A] = b_in;
    assign lane_sel[LANE_TO_A] = b_use_held;
    assign lane_en [LANE_TO_A] = a_oe;

    assign lane_clk[LANE_TO_B] = cap_clk_a;
    assign lane_cap[LANE_TO_B] = a_in;
    assign lane_sel[LANE_TO_B] = a_use_held;
    assign lane_en [LANE_TO_B] = b_oe;

    for (genvar g = 0; g < XCVR_LANES; g++) begin : g_lane
        xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold (
            .cap_clk (lane_clk[g]),
            .rst_n   (rst_n),
            .bus_in  (lane_cap[g]),
            .held    (lane_held[g])
        );

        xcvr_route #(.WIDTH(WIDTH)) u_route (
            .enable   (lane_en[g]),
            .use_held (lane_sel[g]),
            .live     (lane_cap[g]),
            .held     (lane_held[g]),
            .drive    (lane_out[g])
        );
    end

    assign hold_a = lane_held[LANE_TO_B];
    assign hold_b = lane_held[LANE_TO_A];
    assign a_out  = lane_out[LANE_TO_A];
    assign b_out  = lane_out[LANE_TO_B];

endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             cap_clk_a,
    input logic             cap_clk_b,
    input logic             rst_n,
    input logic             isolate,
    input logic             toward_b,
    input logic             a_use_held,
    input logic             b_use_held,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic [WIDTH-1:0] hold_a,
    input logic [WIDTH-1:0] hold_b
);

    assert_capture_a_R1: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        1'b1 |=> hold_a == $past(a_in));

    assert_capture_b_R1: assert property (@(posedge cap_clk_b) disable iff (!rst_n)
        1'b1 |=> hold_b == $past(b_in));

    assert_isolated_R2: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        isolate |-> (!a_oe && !b_oe));

    assert_one_driver_R3: assert property (@(posedge cap_clk_b) disable iff (!rst_n)
        !isolate |-> ($countones({a_oe, b_oe}) == 1 && b_oe == toward_b));

    assert_live_to_b_R4: assert property (@(posedge cap_clk_b) disable iff (!rst_n)
        (b_oe && !a_use_held) |-> b_out == a_in);

    assert_held_to_b_R5: assert property (@(posedge cap_clk_b) disable iff (!rst_n)
        (b_oe && a_use_held) |-> b_out == hold_a);

    assert_live_to_a_R6: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        (a_oe && !b_use_held) |-> a_out == b_in);

    assert_held_to_a_R7: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        (a_oe && b_use_held) |-> a_out == hold_b);

    // R8: word captured at one edge is what the held-mode output shows at the next
    assert_cap_then_drive_b_R8: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        1'b1 |=> ((b_oe && a_use_held) -> b_out == $past(a_in)));

    assert_cap_then_drive_a_R8: assert property (@(posedge cap_clk_b) disable iff (!rst_n)
        1'b1 |=> ((a_oe && b_use_held) -> a_out == $past(b_in)));

    assert_idle_zero_R10: assert property (@(posedge cap_clk_a) disable iff (!rst_n)
        (!a_oe -> a_out == '0) && (!b_oe -> b_out == '0));

endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .cap_clk_a  (cap_clk_a),
    .cap_clk_b  (cap_clk_b),
    .rst_n      (rst_n),
    .isolate    (isolate),
    .toward_b   (toward_b),
    .a_use_held (a_use_held),
    .b_use_held (b_use_held),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .hold_a     (hold_a),
    .hold_b     (hold_b)
);

// File: tb/test_dual_bus_xcvr.sv
module test_dual_bus_xcvr;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         cap_clk_a = 1'b0;
    logic         cap_clk_b = 1'b0;
    logic         rst_n = 1'b0;
    logic         isolate = 1'b1;
    logic         toward_b = 1'b0;
    logic         a_use_held = 1'b0;
    logic         b_use_held = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_bus_xcvr #(.WIDTH(W)) i_dual_bus_xcvr (
        .cap_clk_a  (cap_clk_a),
        .cap_clk_b  (cap_clk_b),
        .rst_n      (rst_n),
        .isolate    (isolate),
        .toward_b   (toward_b),
        .a_use_held (a_use_held),
        .b_use_held (b_use_held),
        .a_in       (a_in),
        .a_out      (a_out),
        .a_oe       (a_oe),
        .b_in       (b_in),
        .b_out      (b_out),
        .b_oe       (b_oe)
    );

    typedef struct packed {
        logic         iso;
        logic         dir;
        logic         sa;
        logic         sb;
        logic [W-1:0] ain;
        logic [W-1:0] bin;
        logic         eaoe;
        logic         eboe;
        logic [W-1:0] eaout;
        logic [W-1:0] ebout;
    } row_t;

    // registers preloaded with A=3C, B=C3 before this table is walked
    localparam int NROWS = 16;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1,1'b0,1'b0,1'b0, 8'h11,8'h22, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b0,1'b0,1'b1, 8'h21,8'h32, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b0,1'b1,1'b0, 8'h31,8'h42, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b0,1'b1,1'b1, 8'h33,8'h44, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b1,1'b0,1'b0, 8'h55,8'h66, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b1,1'b0,1'b1, 8'h65,8'h76, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b1,1'b1,1'b0, 8'h75,8'h86, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b1,1'b1,1'b1,1'b1, 8'h77,8'h88, 1'b0,1'b0, 8'h00,8'h00},
        '{1'b0,1'b1,1'b0,1'b0, 8'h12,8'h34, 1'b0,1'b1, 8'h00,8'h12},
        '{1'b0,1'b1,1'b0,1'b1, 8'h56,8'h78, 1'b0,1'b1, 8'h00,8'h56},
        '{1'b0,1'b1,1'b1,1'b0, 8'h9A,8'hBC, 1'b0,1'b1, 8'h00,8'h3C},
        '{1'b0,1'b1,1'b1,1'b1, 8'hDE,8'hF0, 1'b0,1'b1, 8'h00,8'h3C},
        '{1'b0,1'b0,1'b0,1'b0, 8'h13,8'h57, 1'b1,1'b0, 8'h57,8'h00},
        '{1'b0,1'b0,1'b1,1'b0, 8'h24,8'h68, 1'b1,1'b0, 8'h68,8'h00},
        '{1'b0,1'b0,1'b0,1'b1, 8'h9B,8'hDF, 1'b1,1'b0, 8'hC3,8'h00},
        '{1'b0,1'b0,1'b1,1'b1, 8'h02,8'h46, 1'b1,1'b0, 8'hC3,8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic iso, input logic dir,
                            input logic sa, input logic sb);
        @(negedge clk);
        isolate    = iso;
        toward_b   = dir;
        a_use_held = sa;
        b_use_held = sb;
    endtask

    task automatic pulse_a();
        @(posedge clk) cap_clk_a = 1'b1;
        @(posedge clk) cap_clk_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_b();
        @(posedge clk) cap_clk_b = 1'b1;
        @(posedge clk) cap_clk_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R11: reset state, read through held mode on both sides
        repeat (3) @(negedge clk);
        a_in = 8'hFF; b_in = 8'hFF;
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R11", "b_out held during reset", 32'(b_out), 32'h00);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R11", "a_out held during reset", 32'(a_out), 32'h00);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R11", "a_out held after reset", 32'(a_out), 32'h00);

        // R1 R2: capture while isolated, then preload for the table
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'h3C; pulse_a();
        b_in = 8'hC3; pulse_b();
        check("R2", "oe pair isolated", 32'({a_oe, b_oe}), 32'h0);

        // table walk: all isolate/direction/select combinations (R2 R3 R4 R5 R6 R7 R9 R10)
        for (int i = 0; i < NROWS; i++) begin
            set_ctrl(ROWS[i].iso, ROWS[i].dir, ROWS[i].sa, ROWS[i].sb);
            a_in = ROWS[i].ain;
            b_in = ROWS[i].bin;
            @(posedge clk);
            @(negedge clk);
            check("R3", $sformatf("row %0d enables", i),
                  32'({a_oe, b_oe}), 32'({ROWS[i].eaoe, ROWS[i].eboe}));
            check("R9", $sformatf("row %0d outputs", i),
                  32'({a_out, b_out}), 32'({ROWS[i].eaout, ROWS[i].ebout}));
            checks++;
            if (a_oe && b_oe) begin
                errors++;
                $display("FAIL R3 row %0d both enabled: actual 11 expected not 11", i);
            end
        end

        // R1 R5: word stored in isolation, then driven while live input moves
        set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        a_in = 8'h81; pulse_a();
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'h7E;
        @(negedge clk);
        check("R5", "isolated capture held on b_out", 32'(b_out), 32'h81);
        a_in = 8'h18;
        @(negedge clk);
        check("R5", "b_out ignores live a_in", 32'(b_out), 32'h81);

        // R1: B register captures while bus B is the driven side
        b_in = 8'hA7; pulse_b();
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        b_in = 8'h00;
        @(negedge clk);
        check("R1", "B captured while B driven", 32'(a_out), 32'hA7);
        check("R7", "a_out ignores live b_in", 32'(a_out), 32'hA7);

        // R8: capture and held drive in one operation, both directions
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'h99; pulse_a();
        check("R8", "new A word on b_out after edge", 32'(b_out), 32'h99);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        b_in = 8'h66; pulse_b();
        check("R8", "new B word on a_out after edge", 32'(a_out), 32'h66);

        // R6 R4: live path follows input in the same cycle
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        b_in = 8'h5D;
        @(negedge clk);
        check("R6", "a_out live b_in", 32'(a_out), 32'h5D);
        check("R10", "b_out idle", 32'(b_out), 32'h00);
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b1);
        a_in = 8'hE4;
        @(negedge clk);
        check("R4", "b_out live a_in", 32'(b_out), 32'hE4);
        check("R10", "a_out idle", 32'(a_out), 32'h00);

        done = 1'b1;
        finish_run();
    end

endmodule